// File: doc/BRIEF.md
# Toggle Interval Logger

The logger watches one single-bit input that has no timing relation to the logging clock. Each time the input changes level, the logger writes one entry into an on-chip buffer. An entry records the level the input moved to and how many clock cycles the level before it lasted. Before any comparison, the raw input passes through a chain of at least two flip-flops. This prevents a sample caught mid-transition from producing an entry that repeats the previous level.

A processor reads entries back through a word-indexed read port. The current entry count and a full flag are visible at all times. A single-cycle clear strobe empties the log and restarts capture, and a synchronous reset does the same.

When the buffer is full, capture stops. The input level and the interval counter keep being tracked, so a later clear starts from a correct reference level. The interval counter saturates at its largest value and never spills into the level bit.

Top module: `lrl_logger`

## Requirements
- R1: After reset or after a clear strobe sampled at a clock edge, `wr_count` is 0 and `full` is 0 from the next cycle on.
- R2: An entry is stored only when the synchronized input differs from the stored reference level; while the input holds its level, `wr_count` does not change, and it never grows by more than one per cycle.
- R3: Bit `ENT_W-1` (bit 31 by default) of an entry is the level the input moved to, so consecutive entries always carry opposite values in that bit.
- R4: Bits `CNT_W-1:0` of an entry hold the number of clock cycles the previous synchronized level lasted. The counter restarts at 1 after each logged change. For the first entry after a clear sampled at edge q, where the input changes just after edge c, the count is c - q + 3.
- R5: When `wr_count` reaches `DEPTH`, `full` is 1; further input changes store nothing, and `wr_count` stays at `DEPTH` until a clear or reset.
- R6: A clear sampled at the same edge as a pending change wins: no entry is stored, and the new level becomes the reference, so no entry follows until the input changes again.
- R7: A request with `rd_valid` high at an edge returns the stored entry for `rd_idx` on `rd_data`, with `rd_resp_valid` high, in the next cycle; `rd_resp_valid` is low in any cycle after an edge without a request.
- R8: The interval count saturates at its all-ones value (2^CNT_W - 1) instead of wrapping.
- R9: With the default two synchronizer stages, an input change made just after edge c is stored at edge c+3: `wr_count` is unchanged after edge c+2 and one higher after edge c+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logging clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_async | input | 1 | Raw input, asynchronous to `clk` |
| clr_strobe | input | 1 | One-cycle strobe that empties the log and restarts capture |
| rd_valid | input | 1 | Read request; always accepted |
| rd_idx | input | AW ($clog2(DEPTH)) | Entry index to read |
| rd_resp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | ENT_W (CNT_W+1) | Entry: level in the top bit, interval count below |
| wr_count | output | IDX_W ($clog2(DEPTH+1)) | Number of stored entries |
| full | output | 1 | High when `wr_count` equals `DEPTH` |

## Verification
The read port has no back-pressure. The assertions therefore assume the requester takes each response in the cycle it appears, and that a request in one cycle always produces a response in the next.

The assertions also assume `clr_strobe` and `rd_valid` change only away from the clock edge. The bench drives these inputs a fraction of a period after the edge.

`din_async` is the only input allowed to change at arbitrary points in the period. The bench moves it at varying offsets inside the cycle, but never at the edge itself, so the expected interval counts stay exact whole cycles. It also holds the input steady for several cycles before each clear, so that the reference level loaded by the clear is well defined.

// File: rtl/lrl_pkg.sv
package lrl_pkg;

  // smallest synchronizer chain accepted; shorter requests are raised to it
  localparam int unsigned LRL_SYNC_MIN = 2;

  // action chosen by the level tracker on each clock
  typedef enum logic [1:0] {
    TRK_HOLD  = 2'd0,
    TRK_LOG   = 2'd1,
    TRK_CLEAR = 2'd2
  } trk_act_e;

  // width able to hold every count from 0 up to and including depth
  function automatic int unsigned lrl_idx_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // address width of a buffer of the given depth (at least one bit)
  function automatic int unsigned lrl_addr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/lrl_sync.sv
module lrl_sync
  import lrl_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q
);

  localparam int unsigned N = (STAGES < LRL_SYNC_MIN) ? LRL_SYNC_MIN : STAGES;

  logic [N-1:0] chain_q;

  // free-running chain: keeps sampling during reset so the tracker can load
  // a settled level as its reference
  always_ff @(posedge clk) begin
    chain_q <= {chain_q[N-2:0], d_async};
  end

  assign q = chain_q[N-1];

endmodule

// File: rtl/lrl_track.sv
module lrl_track
  import lrl_pkg::*;
#(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lvl_s,
  output logic             log_req,
  output logic             new_lvl,
  output logic [CNT_W-1:0] run_len
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             ref_q;
  logic [CNT_W-1:0] cnt_q;
  trk_act_e         act;

  // clear and reset take priority over a detected change
  always_comb begin
    if (!rst_n || clr)       act = TRK_CLEAR;
    else if (lvl_s != ref_q) act = TRK_LOG;
    else                     act = TRK_HOLD;
  end

  always_ff @(posedge clk) begin
    unique case (act)
      TRK_CLEAR, TRK_LOG: begin
        ref_q <= lvl_s;
        cnt_q <= CNT_ONE;
      end
      default: begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      end
    endcase
  end

  assign log_req = (act == TRK_LOG);
  assign new_lvl = lvl_s;
  assign run_len = cnt_q;

endmodule

// File: rtl/lrl_store.sv
module lrl_store
  import lrl_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned ENT_W = 32,
  localparam int unsigned AW    = lrl_addr_w(DEPTH),
  localparam int unsigned IDX_W = lrl_idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_req,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_idx,
  output logic             rd_resp_valid,
  output logic [ENT_W-1:0] rd_data,
  output logic [IDX_W-1:0] count,
  output logic             full
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic             full_w;
  logic             do_wr;

  assign full_w = (idx_q == IDX_W'(DEPTH));
  assign do_wr  = wr_req && !full_w;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  idx_q <= '0;
    else if (do_wr)     idx_q <= idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[idx_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_resp_valid <= 1'b0;
    else        rd_resp_valid <= rd_valid;
  end

  always_ff @(posedge clk) begin
    if (rd_valid) rd_data <= (32'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
  end

  assign count = idx_q;
  assign full  = full_w;

endmodule

// File: rtl/lrl_logger.sv
module lrl_logger
  import lrl_pkg::*;
#(
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned CNT_W       = 31,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ENT_W = CNT_W + 1,
  localparam int unsigned AW    = lrl_addr_w(DEPTH),
  localparam int unsigned IDX_W = lrl_idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_async,
  input  logic             clr_strobe,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_idx,
  output logic             rd_resp_valid,
  output logic [ENT_W-1:0] rd_data,
  output logic [IDX_W-1:0] wr_count,
  output logic             full
);

  logic             lvl_s;
  logic             log_req;
  logic             new_lvl;
  logic [CNT_W-1:0] run_len;

  lrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (din_async),
    .q       (lvl_s)
  );

  lrl_track #(.CNT_W(CNT_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_strobe),
    .lvl_s   (lvl_s),
    .log_req (log_req),
    .new_lvl (new_lvl),
    .run_len (run_len)
  );

  lrl_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr_strobe),
    .wr_req        (log_req),
    .wr_data       ({new_lvl, run_len}),
    .rd_valid      (rd_valid),
    .rd_idx        (rd_idx),
    .rd_resp_valid (rd_resp_valid),
    .rd_data       (rd_data),
    .count         (wr_count),
    .full          (full)
  );

endmodule

// File: rtl/lrl_logger_chk.sv
module lrl_logger_chk #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_strobe,
  input logic             rd_valid,
  input logic             rd_resp_valid,
  input logic [IDX_W-1:0] wr_count,
  input logic             full
);

  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |=> (wr_count == '0) && !full);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_strobe |=> (wr_count == $past(wr_count)) || (wr_count == $past(wr_count) + IDX_W'(1)));

  // R5
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_strobe) |=> full && $stable(wr_count));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid || !rd_valid |-> 32'(wr_count) <= DEPTH);

  // R7
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid);

  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_resp_valid);

endmodule

bind lrl_logger lrl_logger_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_strobe    (clr_strobe),
  .rd_valid      (rd_valid),
  .rd_resp_valid (rd_resp_valid),
  .wr_count      (wr_count),
  .full          (full)
);

// File: tb/lrl_logger_bench.sv
`timescale 1ns/1ps
module lrl_logger_bench;

  localparam int DEPTH   = 8;
  localparam int S_DEPTH = 4;
  localparam int S_CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // main instance
  logic        din = 1'b0, clr = 1'b0, rd_valid = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic        rd_resp_valid, full;
  logic [31:0] rd_data;
  logic [3:0]  wr_count;

  lrl_logger #(.DEPTH(DEPTH)) u_lrl_logger (
    .clk(clk), .rst_n(rst_n), .din_async(din), .clr_strobe(clr),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_resp_valid(rd_resp_valid),
    .rd_data(rd_data), .wr_count(wr_count), .full(full)
  );

  // small instance for saturation
  logic       s_din = 1'b0, s_clr = 1'b0, s_rd_valid = 1'b0;
  logic [1:0] s_rd_idx = '0;
  logic       s_rd_resp_valid, s_full;
  logic [6:0] s_rd_data;
  logic [2:0] s_count;

  lrl_logger #(.DEPTH(S_DEPTH), .CNT_W(S_CNT_W)) u_small (
    .clk(clk), .rst_n(rst_n), .din_async(s_din), .clr_strobe(s_clr),
    .rd_valid(s_rd_valid), .rd_idx(s_rd_idx), .rd_resp_valid(s_rd_resp_valid),
    .rd_data(s_rd_data), .wr_count(s_count), .full(s_full)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // reference model of the main instance
  logic [31:0] exp_e [64];
  int nexp = 0, prev_c = 0, clr_a = 0;
  bit first = 1'b1;

  task automatic do_clear();
    @(posedge clk); #1 clr = 1'b1; clr_a = cyc;
    @(posedge clk); #1 clr = 1'b0;
    nexp = 0; first = 1'b1;
  endtask

  task automatic toggle(input int n);
    int c, cnt;
    repeat (n) @(posedge clk);
    #(0.5 + 0.5 * ($urandom % 6));
    din = ~din;
    c = cyc;
    cnt = first ? (c - clr_a + 2) : (c - prev_c);
    first = 1'b0;
    prev_c = c;
    if (nexp < DEPTH) begin
      exp_e[nexp] = {din, 31'(cnt)};
      nexp++;
    end
  endtask

  task automatic verify(input string tag);
    logic prev_lvl;
    repeat (5) @(posedge clk);
    #1;
    chk(wr_count == 4'(nexp), {tag, " R2 count"}, wr_count, nexp);
    chk(full == (nexp == DEPTH), {tag, " R5 full"}, full, nexp == DEPTH);
    prev_lvl = 1'b0;
    for (int i = 0; i < nexp; i++) begin
      rd_valid = 1'b1; rd_idx = 3'(i);
      @(posedge clk); #1;
      chk(rd_resp_valid == 1'b1, {tag, " R7 resp"}, rd_resp_valid, 1);
      chk(rd_data[30:0] == exp_e[i][30:0], {tag, " R4 interval"}, rd_data[30:0], exp_e[i][30:0]);
      chk(rd_data[31] == exp_e[i][31], {tag, " R3 level"}, rd_data[31], exp_e[i][31]);
      if (i > 0) chk(rd_data[31] != prev_lvl, {tag, " R3 alternate"}, rd_data[31], !prev_lvl);
      prev_lvl = rd_data[31];
    end
    rd_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(wr_count == 0, "R1 reset count", wr_count, 0);
    chk(full == 1'b0, "R1 reset full", full, 0);
    chk(rd_resp_valid == 1'b0, "R7 reset resp", rd_resp_valid, 0);
  endtask

  task automatic t_basic();
    int hold;
    do_clear();
    repeat (4) @(posedge clk);
    toggle(5); toggle(9); toggle(3); toggle(12); toggle(7);
    verify("basic");
    hold = wr_count;
    repeat (20) @(posedge clk); #1;
    chk(wr_count == 4'(hold), "R2 steady level", wr_count, hold);
  endtask

  task automatic t_latency();
    do_clear();
    repeat (4) @(posedge clk);
    toggle(1);
    @(posedge clk); @(posedge clk); #1;
    chk(wr_count == 0, "R9 not yet stored", wr_count, 0);
    @(posedge clk); #1;
    chk(wr_count == 1, "R9 stored at c+3", wr_count, 1);
    toggle(6);
    verify("latency");
  endtask

  task automatic t_fill();
    do_clear();
    repeat (4) @(posedge clk);
    for (int i = 0; i < 11; i++) toggle(4 + (i % 3));
    verify("fill");
    chk(wr_count == 4'(DEPTH), "R5 stops at depth", wr_count, DEPTH);
  endtask

  task automatic t_clear_wins();
    do_clear();
    repeat (4) @(posedge clk);
    toggle(2);
    @(posedge clk);
    @(posedge clk); #1 clr = 1'b1; clr_a = cyc;
    @(posedge clk); #1 clr = 1'b0;
    nexp = 0; first = 1'b1;
    chk(wr_count == 0, "R6 clear beats change", wr_count, 0);
    repeat (6) @(posedge clk); #1;
    chk(wr_count == 0, "R6 no entry after clear", wr_count, 0);
    toggle(7); toggle(4);
    verify("clear_wins");
  endtask

  task automatic t_rd_idle();
    rd_valid = 1'b0;
    @(posedge clk); #1;
    chk(rd_resp_valid == 1'b0, "R7 idle resp", rd_resp_valid, 0);
  endtask

  task automatic t_saturate();
    @(posedge clk); #1 s_clr = 1'b1;
    @(posedge clk); #1 s_clr = 1'b0;
    repeat (100) @(posedge clk);
    #1.5 s_din = ~s_din;
    repeat (5) @(posedge clk); #1;
    chk(s_count == 1, "R8 small count", s_count, 1);
    s_rd_valid = 1'b1; s_rd_idx = 2'd0;
    @(posedge clk); #1;
    s_rd_valid = 1'b0;
    chk(s_rd_data[5:0] == 6'd63, "R8 saturated interval", s_rd_data[5:0], 63);
    chk(s_rd_data[6] == 1'b1, "R3 small level", s_rd_data[6], 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_basic();
    t_latency();
    t_fill();
    t_clear_wins();
    t_rd_idle();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule